// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block converts a 64-bit virtual address into a page-frame address by walking in-memory translation tables. A walk starts from one of three address-space designation registers (primary, secondary, home), chosen by the translation mode and the access kind. A 2-bit type field in the designation gives the first table level. The walk then descends through up to three region levels and a segment level to a page table. Each table entry is fetched with a single 64-bit read on a plain request/response memory port, and only one read is ever in flight.

A walk ends with either a page-frame address and read/write/execute permissions, or a fault code and a translation exception code. A designation marked as real space bypasses the tables. With the enhanced-translation enable set, a segment entry can map a 1 MB frame directly. Each region level checks the next index against an offset/length window. The walker accepts a new request only when idle and reports the outcome with a one-cycle completion pulse.

Top module: `xlat_walker`

## Requirements
- R1: A designation with bit 5 set (real space) completes with frame = virtual address with bits 11:0 cleared, full write permission, and no memory read.
- R2: Designation type (bits 3:2) 3 = region-first, 2 = region-second, 1 = region-third, 0 = segment. For types 2, 1 and 0 the address bits above 52, 41 and 30 respectively must all be zero, else fault code 0x38 with no read.
- R3: The 2-bit top of the first index (address bits 63:62, 52:51, 41:40, 30:29 for types 3..0) above the designation length field (bits 1:0) gives the start level's fault code with no read: region-first 0x39, region-second 0x3A, region-third 0x3B, segment 0x10.
- R4: A table entry is read at origin + index*8. The index is address bits 63:53, 52:42, 41:31 or 30:20 for levels 3..0, and the origin is the designation or region entry with bits 11:0 cleared.
- R5: An entry with bit 5 set gives its own level's fault code. An entry whose type bits 3:2 differ from its level gives fault 0x12.
- R6: In a region entry, the next level's top 2 index bits must lie within [bits 7:6, bits 1:0] of the entry, else the next level's fault code.
- R7: A segment entry with bit 10 set while enhanced translation is enabled gives frame = entry bits 63:20 with address bits 19:12. Otherwise bit 10 is ignored and the walk goes to the page table.
- R8: The page entry is read at (segment entry with bits 10:0 cleared) + address bits 19:12 * 8. Page entry bit 10 set gives 0x11, bit 8 set gives 0x12, else the frame is entry bits 63:12.
- R9: Bit 9 of a page or segment entry removes write permission, as does bit 9 of a region entry when enhanced translation is enabled. A store (access 1) ending without write permission gives fault 0x04.
- R10: On a fault the exception code is the page-aligned address ORed with 0x400 for a store (0x800 otherwise), with 0x4 for a protection fault, and with the space code (0 primary, 2 secondary, 3 home) of the designation walked.
- R11: Modes are 0 primary, 2 secondary, 3 home. In secondary mode a fetch (access 2) walks the primary designation and returns no read or write permission. Secondary data accesses walk the secondary designation and return no execute permission.
- R12: A read response with the error flag set aborts the walk with fault 0x05. Only one read is outstanding, and the request input is not ready while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk |
| reqReady | output | 1 | Walker idle, request accepted |
| reqVaddr | input | 64 | Virtual address |
| reqAccess | input | 2 | 0 read, 1 store, 2 fetch |
| reqMode | input | 2 | 0 primary, 2 secondary, 3 home |
| priDesig | input | 64 | Primary space designation |
| secDesig | input | 64 | Secondary space designation |
| homeDesig | input | 64 | Home space designation |
| edatEn | input | 1 | Enhanced translation enable |
| memReqValid | output | 1 | Table read request (one cycle) |
| memReqAddr | output | 64 | Table read address |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 64 | Read data |
| memRspErr | input | 1 | Read error flag |
| doneValid | output | 1 | Walk complete (one cycle) |
| doneFault | output | 8 | Fault code, 0 on success |
| doneFrame | output | 64 | Page-frame address |
| doneTec | output | 64 | Translation exception code |
| permRead | output | 1 | Read allowed |
| permWrite | output | 1 | Write allowed |
| permExec | output | 1 | Execute allowed |

## Verification
Two decisions can land in the same cycle: decoding the last table entry and the store-protection check. A read-only page or segment entry returned for a store must give a protection fault in the very cycle the frame would otherwise be produced. The other pair is a memory error and an entry that would itself fault: the bench returns invalid-bit data together with the error flag and expects the addressing code. The bench reference model predicts every table read address and the final result. It compares them on each clock, with response latencies of one to three cycles.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int VA_W     = 64;
  localparam int PG_BITS  = 12;
  localparam int IDX_W    = 11;
  localparam int PX_W     = 8;
  localparam int SEG_SHIFT = PG_BITS + PX_W;
  localparam int PT_ALIGN = 11;

  localparam logic [VA_W-1:0] PG_LOW    = {{(VA_W-PG_BITS){1'b0}}, {PG_BITS{1'b1}}};
  localparam logic [VA_W-1:0] PT_LOW    = {{(VA_W-PT_ALIGN){1'b0}}, {PT_ALIGN{1'b1}}};
  localparam logic [VA_W-1:0] LARGE_LOW = {{(VA_W-SEG_SHIFT){1'b0}}, {SEG_SHIFT{1'b1}}};

  // Entry bit positions
  localparam int B_REAL = 5;
  localparam int B_INV  = 5;
  localparam int B_RO   = 9;
  localparam int B_FC   = 10;
  localparam int B_PINV = 10;
  localparam int B_PRES = 8;

  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;
  localparam logic [1:0] MODE_SEC  = 2'd2;
  localparam logic [1:0] MODE_HOME = 2'd3;

  localparam logic [7:0] FLT_NONE = 8'h00;
  localparam logic [7:0] FLT_PROT = 8'h04;
  localparam logic [7:0] FLT_ADDR = 8'h05;
  localparam logic [7:0] FLT_SEG  = 8'h10;
  localparam logic [7:0] FLT_PAGE = 8'h11;
  localparam logic [7:0] FLT_SPEC = 8'h12;
  localparam logic [7:0] FLT_ASCE = 8'h38;
  localparam logic [7:0] FLT_RGN1 = 8'h39;
  localparam logic [7:0] FLT_RGN2 = 8'h3A;
  localparam logic [7:0] FLT_RGN3 = 8'h3B;

  typedef enum logic [1:0] {VD_NEXT = 2'd0, VD_DONE = 2'd1, VD_FAULT = 2'd2} verdict_e;

  typedef struct packed {
    logic capture;
    logic evalDesig;
    logic evalEntry;
  } strobe_t;

  function automatic logic [7:0] levelFault(input logic [1:0] lvl);
    case (lvl)
      2'd3:    return FLT_RGN1;
      2'd2:    return FLT_RGN2;
      2'd1:    return FLT_RGN3;
      default: return FLT_SEG;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] idxAt(input logic [VA_W-1:0] va, input logic [1:0] lvl);
    logic [VA_W-1:0] s;
    s = va >> (SEG_SHIFT + IDX_W * int'(lvl));
    return s[IDX_W-1:0];
  endfunction

  function automatic logic [1:0] topAt(input logic [VA_W-1:0] va, input logic [1:0] lvl);
    logic [VA_W-1:0] s;
    s = va >> (SEG_SHIFT + IDX_W * int'(lvl) + IDX_W - 2);
    return s[1:0];
  endfunction

  function automatic logic hiBad(input logic [VA_W-1:0] va, input logic [1:0] lvl);
    if (lvl == 2'd3) return 1'b0;
    return (va >> (SEG_SHIFT + IDX_W * (int'(lvl) + 1))) != '0;
  endfunction

  function automatic logic [VA_W-1:0] slot(input logic [VA_W-1:0] base, input logic [IDX_W-1:0] idx);
    return base + {{(VA_W-IDX_W-3){1'b0}}, idx, 3'b000};
  endfunction
endpackage

// File: rtl/xw_datapath.sv
module xw_datapath
  import xw_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobe,
  input  logic [VA_W-1:0] reqVaddr,
  input  logic [1:0]      reqAccess,
  input  logic [1:0]      reqMode,
  input  logic [VA_W-1:0] priDesig,
  input  logic [VA_W-1:0] secDesig,
  input  logic [VA_W-1:0] homeDesig,
  input  logic            edatEn,
  input  logic [VA_W-1:0] memRspData,
  input  logic            memRspErr,
  input  logic            doneValid,
  output verdict_e        verdict,
  output logic [VA_W-1:0] tableAddr,
  output logic [VA_W-1:0] frame,
  output logic [VA_W-1:0] tec,
  output logic [7:0]      fault,
  output logic            permRead,
  output logic            permWrite,
  output logic            permExec
);
  logic [VA_W-1:0] vaReg, desigReg, tableAddrReg, frameReg;
  logic [1:0]      accReg, spaceReg, lvlReg;
  logic            pteStage, rOk, wOk, xOk, secFetch;
  logic [7:0]      faultReg;

  // request-time selection
  logic [VA_W-1:0] selDesig;
  logic [1:0]      selSpace;
  logic            selR, selW, selX, isSecFetch;

  always_comb begin
    isSecFetch = (reqMode == MODE_SEC) && (reqAccess == ACC_FETCH);
    selR = 1'b1; selW = 1'b1; selX = 1'b1;
    if (isSecFetch) begin
      selDesig = priDesig; selSpace = 2'd0; selR = 1'b0; selW = 1'b0;
    end else if (reqMode == MODE_SEC) begin
      selDesig = secDesig; selSpace = 2'd2; selX = 1'b0;
    end else if (reqMode == MODE_HOME) begin
      selDesig = homeDesig; selSpace = 2'd3;
    end else begin
      selDesig = priDesig; selSpace = 2'd0;
    end
  end

  // stage evaluation
  logic [VA_W-1:0] addrNx, frameNx, ent;
  logic [1:0]      lvlNx, nt;
  logic            pteNx, wNx;
  logic [7:0]      faultNx;

  always_comb begin
    ent     = memRspData;
    verdict = VD_NEXT;
    faultNx = FLT_NONE;
    addrNx  = tableAddrReg;
    lvlNx   = lvlReg;
    pteNx   = pteStage;
    frameNx = frameReg;
    wNx     = wOk;
    nt      = '0;
    if (strobe.evalDesig) begin
      if (desigReg[B_REAL]) begin
        verdict = VD_DONE;
        frameNx = vaReg;
      end else if (hiBad(vaReg, desigReg[3:2])) begin
        verdict = VD_FAULT; faultNx = FLT_ASCE;
      end else if (topAt(vaReg, desigReg[3:2]) > desigReg[1:0]) begin
        verdict = VD_FAULT; faultNx = levelFault(desigReg[3:2]);
      end else begin
        addrNx = slot(desigReg & ~PG_LOW, idxAt(vaReg, desigReg[3:2]));
        lvlNx  = desigReg[3:2];
        pteNx  = 1'b0;
      end
    end else if (memRspErr) begin
      verdict = VD_FAULT; faultNx = FLT_ADDR;
    end else if (pteStage) begin
      if (ent[B_PINV]) begin
        verdict = VD_FAULT; faultNx = FLT_PAGE;
      end else if (ent[B_PRES]) begin
        verdict = VD_FAULT; faultNx = FLT_SPEC;
      end else begin
        verdict = VD_DONE;
        frameNx = ent & ~PG_LOW;
        if (ent[B_RO]) wNx = 1'b0;
      end
    end else if (ent[B_INV]) begin
      verdict = VD_FAULT; faultNx = levelFault(lvlReg);
    end else if (ent[3:2] != lvlReg) begin
      verdict = VD_FAULT; faultNx = FLT_SPEC;
    end else if (lvlReg == 2'd0) begin
      if (ent[B_RO]) wNx = 1'b0;
      if (ent[B_FC] && edatEn) begin
        verdict = VD_DONE;
        frameNx = (ent & ~LARGE_LOW) | (vaReg & LARGE_LOW);
      end else begin
        addrNx = (ent & ~PT_LOW) + {{(VA_W-PX_W-3){1'b0}}, vaReg[SEG_SHIFT-1:PG_BITS], 3'b000};
        pteNx  = 1'b1;
      end
    end else begin
      nt = topAt(vaReg, lvlReg - 2'd1);
      if (nt < ent[7:6] || nt > ent[1:0]) begin
        verdict = VD_FAULT; faultNx = levelFault(lvlReg - 2'd1);
      end else begin
        if (edatEn && ent[B_RO]) wNx = 1'b0;
        addrNx = slot(ent & ~PG_LOW, idxAt(vaReg, lvlReg - 2'd1));
        lvlNx  = lvlReg - 2'd1;
      end
    end
    if (verdict == VD_DONE && accReg == ACC_STORE && !wNx) begin
      verdict = VD_FAULT; faultNx = FLT_PROT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg <= '0; desigReg <= '0; tableAddrReg <= '0; frameReg <= '0;
      accReg <= '0; spaceReg <= '0; lvlReg <= '0; pteStage <= 1'b0;
      rOk <= 1'b0; wOk <= 1'b0; xOk <= 1'b0; secFetch <= 1'b0; faultReg <= FLT_NONE;
    end else if (strobe.capture) begin
      vaReg    <= reqVaddr & ~PG_LOW;
      accReg   <= reqAccess;
      desigReg <= selDesig;
      spaceReg <= selSpace;
      rOk <= selR; wOk <= selW; xOk <= selX;
      secFetch <= isSecFetch;
      pteStage <= 1'b0;
      faultReg <= FLT_NONE;
    end else if (strobe.evalDesig || strobe.evalEntry) begin
      tableAddrReg <= addrNx;
      lvlReg       <= lvlNx;
      pteStage     <= pteNx;
      frameReg     <= frameNx;
      wOk          <= wNx;
      faultReg     <= faultNx;
    end
  end

  assign tableAddr = tableAddrReg;
  assign frame     = frameReg;
  assign fault     = faultReg;
  assign permRead  = rOk;
  assign permWrite = wOk;
  assign permExec  = xOk;
  assign tec = vaReg
             | ((accReg == ACC_STORE) ? 64'h400 : 64'h800)
             | ((faultReg == FLT_PROT) ? 64'h4 : 64'h0)
             | {{(VA_W-2){1'b0}}, spaceReg};

  a_r8_frame_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && fault == FLT_NONE) |-> (frame & PG_LOW) == '0);
  a_r9_store_has_write: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && fault == FLT_NONE && accReg == ACC_STORE) |-> permWrite);
  a_r1_real_direct: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && fault == FLT_NONE && desigReg[B_REAL]) |-> frame == vaReg);
  a_r11_sec_fetch_perm: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && fault == FLT_NONE && secFetch) |-> (!permRead && !permWrite && permExec));
endmodule

// File: rtl/xw_control.sv
module xw_control
  import xw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     memRspValid,
  input  verdict_e verdict,
  output logic     reqReady,
  output logic     memReqValid,
  output logic     doneValid,
  output strobe_t  strobe
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_ISSUE, S_WAIT, S_RESP} state_e;
  state_e state, stateNx;

  always_comb begin
    strobe.capture   = (state == S_IDLE) && reqValid;
    strobe.evalDesig = (state == S_CHECK);
    strobe.evalEntry = (state == S_WAIT) && memRspValid;
    stateNx = state;
    case (state)
      S_IDLE:  if (reqValid) stateNx = S_CHECK;
      S_CHECK: stateNx = (verdict == VD_NEXT) ? S_ISSUE : S_RESP;
      S_ISSUE: stateNx = S_WAIT;
      S_WAIT:  if (memRspValid) stateNx = (verdict == VD_NEXT) ? S_ISSUE : S_RESP;
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNx;
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_ISSUE);
  assign doneValid   = (state == S_RESP);

  a_r12_single_read: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  a_r12_rsp_when_waiting: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> state == S_WAIT);
  a_r12_done_then_ready: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [VA_W-1:0] reqVaddr,
  input  logic [1:0]      reqAccess,
  input  logic [1:0]      reqMode,
  input  logic [VA_W-1:0] priDesig,
  input  logic [VA_W-1:0] secDesig,
  input  logic [VA_W-1:0] homeDesig,
  input  logic            edatEn,
  output logic            memReqValid,
  output logic [VA_W-1:0] memReqAddr,
  input  logic            memRspValid,
  input  logic [VA_W-1:0] memRspData,
  input  logic            memRspErr,
  output logic            doneValid,
  output logic [7:0]      doneFault,
  output logic [VA_W-1:0] doneFrame,
  output logic [VA_W-1:0] doneTec,
  output logic            permRead,
  output logic            permWrite,
  output logic            permExec
);
  strobe_t  strobe;
  verdict_e verdict;

  xw_control uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .verdict(verdict), .reqReady(reqReady), .memReqValid(memReqValid),
    .doneValid(doneValid), .strobe(strobe)
  );

  xw_datapath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVaddr(reqVaddr),
    .reqAccess(reqAccess), .reqMode(reqMode), .priDesig(priDesig),
    .secDesig(secDesig), .homeDesig(homeDesig), .edatEn(edatEn),
    .memRspData(memRspData), .memRspErr(memRspErr), .doneValid(doneValid),
    .verdict(verdict), .tableAddr(memReqAddr), .frame(doneFrame), .tec(doneTec),
    .fault(doneFault), .permRead(permRead), .permWrite(permWrite), .permExec(permExec)
  );
endmodule

// File: tb/sim_xlat_walker.sv
module sim_xlat_walker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [63:0] reqVaddr = '0;
  logic [1:0] reqAccess = '0, reqMode = '0;
  logic [63:0] priDesig = '0, secDesig = '0, homeDesig = '0;
  logic edatEn = 1'b0;
  logic memRspValid = 1'b0, memRspErr = 1'b0;
  logic [63:0] memRspData = '0;
  logic reqReady, memReqValid, doneValid, permRead, permWrite, permExec;
  logic [63:0] memReqAddr, doneFrame, doneTec;
  logic [7:0] doneFault;

  xlat_walker u0 (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] errAddr = 64'hFFFF_FFFF_FFFF_FFF8;
  int lat = 1, cnt = 0;
  logic [63:0] pendAddr = '0;
  logic [63:0] expQ[$];
  logic [7:0] expFault;
  logic [63:0] expFrame, expTec;
  logic [2:0] expPerm;
  bit busy = 0, gotDone = 0;
  string curTag = "R12";

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [7:0] code(input int l);
    case (l)
      3: return 8'h39;
      2: return 8'h3A;
      1: return 8'h3B;
      default: return 8'h10;
    endcase
  endfunction

  // behavioural reference: expected read addresses and final result
  task automatic model(input logic [63:0] va0, input logic [1:0] acc, input logic [1:0] mode);
    logic [63:0] va, d, e, a, org;
    logic [1:0] sp;
    logic [7:0] f;
    int lvl, nt;
    bit r, w, x, fin;
    expQ.delete();
    va = va0 & ~64'hFFF;
    r = 1; w = 1; x = 1; f = 0; fin = 0; lvl = 0; org = 0;
    expFrame = 0;
    if (mode == 2 && acc == 2) begin d = priDesig; sp = 0; r = 0; w = 0; end
    else if (mode == 2) begin d = secDesig; sp = 2; x = 0; end
    else if (mode == 3) begin d = homeDesig; sp = 3; end
    else begin d = priDesig; sp = 0; end
    if (d[5]) begin expFrame = va; fin = 1; end
    else begin
      lvl = int'(d[3:2]);
      if (lvl < 3 && (va >> (31 + 11 * lvl)) != 0) begin f = 8'h38; fin = 1; end
      else if (((va >> (29 + 11 * lvl)) & 64'h3) > {62'h0, d[1:0]}) begin f = code(lvl); fin = 1; end
      org = d & ~64'hFFF;
    end
    while (!fin) begin
      a = org + ((va >> (20 + 11 * lvl)) & 64'h7FF) * 8;
      expQ.push_back(a);
      e = rd(a);
      fin = 1;
      if (a == errAddr) f = 8'h05;
      else if (e[5]) f = code(lvl);
      else if (int'(e[3:2]) != lvl) f = 8'h12;
      else if (lvl == 0) begin
        if (e[9]) w = 0;
        if (e[10] && edatEn) expFrame = (e & ~64'hFFFFF) | (va & 64'hFF000);
        else begin
          a = (e & ~64'h7FF) + ((va >> 12) & 64'hFF) * 8;
          expQ.push_back(a);
          e = rd(a);
          if (a == errAddr) f = 8'h05;
          else if (e[10]) f = 8'h11;
          else if (e[8]) f = 8'h12;
          else begin
            if (e[9]) w = 0;
            expFrame = e & ~64'hFFF;
          end
        end
      end else begin
        nt = int'((va >> (29 + 11 * (lvl - 1))) & 64'h3);
        if (nt < int'(e[7:6]) || nt > int'(e[1:0])) f = code(lvl - 1);
        else begin
          if (edatEn && e[9]) w = 0;
          org = e & ~64'hFFF;
          lvl = lvl - 1;
          fin = 0;
        end
      end
    end
    if (f == 0 && acc == 1 && !w) f = 8'h04;
    expFault = f;
    expPerm = {r, w, x};
    expTec = va | ((acc == 1) ? 64'h400 : 64'h800) | ((f == 8'h04) ? 64'h4 : 64'h0) | {62'h0, sp};
  endtask

  // per-clock monitor and memory responder
  always @(negedge clk) begin
    if (rstN) begin
      if (memReqValid) begin
        if (expQ.size() == 0) check(0, curTag, "unexpected read", memReqAddr, 64'h0);
        else begin
          check(memReqAddr == expQ[0], curTag, "read address (R4)", memReqAddr, expQ[0]);
          void'(expQ.pop_front());
        end
      end
      if (doneValid) begin
        check(busy, curTag, "completion without request", 64'h1, {63'h0, busy});
        check(doneFault == expFault, curTag, "fault code", {56'h0, doneFault}, {56'h0, expFault});
        if (expFault == 8'h00) begin
          check(doneFrame == expFrame, curTag, "frame", doneFrame, expFrame);
          check({permRead, permWrite, permExec} == expPerm, curTag, "perms rwx",
                {61'h0, permRead, permWrite, permExec}, {61'h0, expPerm});
        end else begin
          check(doneTec == expTec, {curTag, "/R10"}, "exception code", doneTec, expTec);
        end
        busy = 0;
        gotDone = 1;
      end
      memRspValid = 1'b0;
      memRspErr = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          memRspValid = 1'b1;
          memRspData = rd(pendAddr);
          memRspErr = (pendAddr == errAddr);
        end
      end
      if (memReqValid) begin
        cnt = lat;
        pendAddr = memReqAddr;
      end
    end
  end

  task automatic run(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] mode,
                     input string tag);
    model(va, acc, mode);
    curTag = tag;
    gotDone = 0;
    @(negedge clk);
    check(reqReady, tag, "ready before request", {63'h0, reqReady}, 64'h1);
    reqVaddr = va; reqAccess = acc; reqMode = mode; reqValid = 1'b1; busy = 1;
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, {tag, "/R12"}, "busy while walking", {63'h0, reqReady}, 64'h0);
    for (int i = 0; i < 300 && !gotDone; i++) @(negedge clk);
    if (!gotDone) check(0, tag, "walk never completed", 64'h0, 64'h1);
    check(expQ.size() == 0, tag, "reads missing", 64'(expQ.size()), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // primary: segment-type table, length 3
    priDesig = 64'h10003;
    mem[64'h10000] = 64'h20000;        // seg 0 -> page table 0x20000
    mem[64'h10008] = 64'h12300400;     // seg 1 large frame
    mem[64'h10010] = 64'h20;           // seg 2 invalid
    mem[64'h10018] = 64'h20004;        // seg 3 wrong type
    mem[64'h10020] = 64'h20A00;        // seg 4 read-only
    mem[64'h10048] = 64'h20;           // seg 9 errored read, invalid data
    errAddr        = 64'h10048;
    mem[64'h20028] = 64'hABCDE000;     // page 5
    mem[64'h20030] = 64'h55555200;     // page 6 read-only
    mem[64'h20038] = 64'h400;          // page 7 invalid
    mem[64'h20040] = 64'h100;          // page 8 reserved bit
    // secondary: region-third table, length 0
    secDesig = 64'h30004;
    mem[64'h30000] = 64'h40007;
    mem[64'h30008] = 64'h40047;        // offset 1
    mem[64'h40000] = 64'h20000;
    // home: region-first table, length 0
    homeDesig = 64'h5000C;
    mem[64'h50000] = 64'h6020F;        // read-only region entry
    mem[64'h60000] = 64'h7000B;
    mem[64'h70000] = 64'h40007;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !doneValid && !memReqValid, "R12", "reset state",
          {61'h0, reqReady, doneValid, memReqValid}, 64'h4);

    lat = 1; run(64'h5000, 2'd0, 2'd0, "R8");
    lat = 3; run(64'h5000, 2'd2, 2'd0, "R4");
    lat = 2; run(64'h6123, 2'd1, 2'd0, "R9");
    run(64'h6000, 2'd0, 2'd0, "R9");
    run(64'h7000, 2'd0, 2'd0, "R8");
    lat = 1; run(64'h8000, 2'd0, 2'd0, "R8");
    edatEn = 1'b1;
    run(64'h103ABC, 2'd0, 2'd0, "R7");
    edatEn = 1'b0;
    lat = 3; run(64'h103ABC, 2'd0, 2'd0, "R7");
    run(64'h200000, 2'd0, 2'd0, "R5");
    run(64'h300000, 2'd0, 2'd0, "R5");
    lat = 1; run(64'h400000, 2'd1, 2'd0, "R9");
    run(64'h80000000, 2'd0, 2'd0, "R2");
    run(64'h100_0000_0000, 2'd0, 2'd2, "R3");
    run(64'h400_0000_0000, 2'd1, 2'd2, "R2");
    lat = 2; run(64'h5000, 2'd0, 2'd2, "R11");
    run(64'h5000, 2'd1, 2'd2, "R11");
    run(64'h5000, 2'd2, 2'd2, "R11");
    run(64'h80000000, 2'd0, 2'd2, "R6");
    lat = 3; run(64'h5000, 2'd0, 2'd3, "R4");
    run(64'h5000, 2'd1, 2'd3, "R9");
    edatEn = 1'b1;
    run(64'h5000, 2'd1, 2'd3, "R9");
    lat = 1; run(64'h4000_0000_0000_5000, 2'd0, 2'd3, "R3");
    run(64'h900000, 2'd0, 2'd0, "R12");
    run(64'h900000, 2'd1, 2'd0, "R12");
    edatEn = 1'b0;
    homeDesig = 64'h20;
    run(64'h1234ABC, 2'd1, 2'd3, "R1");
    run(64'hFFFF_0000_0000_0FFF, 2'd2, 2'd3, "R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule